// File: doc/BRIEF.md
# Exception Control Register Block

This block keeps the small set of system registers that a 32-bit RISC core needs to take and leave exceptions. When the pipeline signals an exception, the block points fetch at a handler entry in the same cycle. On the following clock edge it stores the program counter of the faulting instruction, the type code of the exception and, where the fault came from a memory access, the offending data address. A return request sends fetch back to the saved program counter and ends handler mode.

A cycle counter with a match register raises a sticky timer interrupt. Software reaches all registers through one move-to/move-from port, addressed by a 5-bit register number. A parameter chooses between a single fixed handler entry and a table of entries indexed by the exception code.

Top module: `exc_ctrl_regs`

## Requirements
- R1: While reset is held, the saved PC (14), cause (13) and bad address (8) read zero, the match register (11) reads 0xFFFFFFFF, the counter (9) reads zero, and exl_o, timer_irq_o and redirect_o are low.
- R2: With VECTORED=0, a cycle with exc_valid_i high drives redirect_o high and redirect_pc_o to 0x80000180 in that same cycle.
- R3: With VECTORED=1, the handler address is 0x80000000 + 32 × exc_code_i, for example 0x80000000 for code 0, 0x80000100 for code 8 and 0x80000140 for code 10.
- R4: An exception taken while exl_o is low loads exc_pc_i into register 14 at the next edge and sets exl_o.
- R5: Register 13 returns the last exception code in bits 6:2 and zero in all other bits. Codes: 0 interrupt, 8 syscall, 10 reserved instruction, 12 overflow.
- R6: Register 8 loads exc_addr_i on an exception only when exc_addr_valid_i is high. Otherwise it keeps its value.
- R7: An exception taken while exl_o is high leaves register 14 unchanged but still updates register 13.
- R8: eret_i drives redirect_o high, with redirect_pc_o equal to register 14 in the same cycle, and clears exl_o at the next edge. If exc_valid_i is high in the same cycle, the exception wins: the handler address is output and exl_o stays set.
- R9: The counter (9) advances by one every cycle. A write to register 9 loads it with wr_data_i in place of the increment.
- R10: timer_irq_o goes high at the edge after the counter equals the match register (11). It then stays high until register 11 is written, and that write clears it at the next edge.
- R11: A write to register 14 loads it unless an exception occurs in the same cycle. Writes to registers 8 and 13 are ignored, and any register number outside 8, 9, 11, 13 and 14 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_valid_i | input | 1 | Exception signalled this cycle |
| exc_code_i | input | 5 | Exception type code |
| exc_pc_i | input | 32 | PC of the faulting or interrupted instruction |
| exc_addr_valid_i | input | 1 | exc_addr_i carries a faulting data address |
| exc_addr_i | input | 32 | Faulting data address |
| eret_i | input | 1 | Return from exception |
| reg_wr_i | input | 1 | Move-to write strobe |
| reg_idx_i | input | 5 | Register number for read and write |
| wr_data_i | input | 32 | Move-to write data |
| rd_data_o | output | 32 | Move-from read data for reg_idx_i |
| redirect_o | output | 1 | Fetch must take redirect_pc_o this cycle |
| redirect_pc_o | output | 32 | Handler entry or return address |
| exl_o | output | 1 | Handler mode active |
| timer_irq_o | output | 1 | Sticky timer match interrupt |

## Verification
Exceptions are applied with each of the four codes, and both the fixed-entry and the vectored instance observe them, so a wrong code-to-address mapping shows up separately from a wrong redirect strobe. A second exception is raised inside an open handler to tell a preserved return address apart from an overwritten one. That exception carries no data address, which separates a gated bad-address load from an unconditional one. A cycle with return and exception together checks the priority. Counter load, match, the sticky interrupt and its clearing by a match-register write are stepped cycle by cycle to pin down the one-edge latency of each. Writes to read-only and unmapped numbers show that writes to the wrong registers are rejected.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned IDX_W = 5;

  typedef enum logic [IDX_W-1:0] {
    CODE_INT = 5'd0,
    CODE_SYS = 5'd8,
    CODE_RI  = 5'd10,
    CODE_OV  = 5'd12
  } exc_code_e;

  localparam logic [IDX_W-1:0] REG_BADADDR = 5'd8;
  localparam logic [IDX_W-1:0] REG_COUNT   = 5'd9;
  localparam logic [IDX_W-1:0] REG_MATCH   = 5'd11;
  localparam logic [IDX_W-1:0] REG_CAUSE   = 5'd13;
  localparam logic [IDX_W-1:0] REG_EPC     = 5'd14;

  localparam logic [31:0] FIXED_ENTRY = 32'h8000_0180;
  localparam logic [31:0] TABLE_BASE  = 32'h8000_0000;
  localparam int unsigned ENTRY_SHIFT = 5;
  localparam int unsigned CODE_LSB    = 2;
endpackage

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter bit          VECTORED = 1'b0
) (
  input  logic [IDX_W-1:0] code_i,
  output logic [XLEN-1:0]  entry_o
);
  generate
    if (VECTORED) begin : g_table
      always_comb entry_o = XLEN'(TABLE_BASE) + (XLEN'(code_i) << ENTRY_SHIFT);
    end else begin : g_fixed
      logic unused_code;
      assign unused_code = ^code_i;
      always_comb entry_o = XLEN'(FIXED_ENTRY);
    end
  endgenerate

  always_comb begin
    assert_entry_aligned_R3 : assert (entry_o[ENTRY_SHIFT-1:0] == '0 || !VECTORED);
  end
endmodule

// File: rtl/exc_capture.sv
module exc_capture
  import exc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exc_valid_i,
  input  logic [IDX_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]  exc_pc_i,
  input  logic             exc_addr_valid_i,
  input  logic [XLEN-1:0]  exc_addr_i,
  input  logic             eret_i,
  input  logic             wr_epc_i,
  input  logic [XLEN-1:0]  wr_data_i,
  output logic [XLEN-1:0]  epc_o,
  output logic [IDX_W-1:0] code_o,
  output logic [XLEN-1:0]  badaddr_o,
  output logic             exl_o
);
  logic [XLEN-1:0]  epc_q, badaddr_q;
  logic [IDX_W-1:0] code_q;
  logic             exl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q     <= '0;
      badaddr_q <= '0;
      code_q    <= '0;
      exl_q     <= 1'b0;
    end else begin
      if (exc_valid_i) begin
        // nested exception keeps the first return address
        if (!exl_q) epc_q <= exc_pc_i;
        code_q <= exc_code_i;
        if (exc_addr_valid_i) badaddr_q <= exc_addr_i;
        exl_q <= 1'b1;
      end else begin
        if (wr_epc_i) epc_q <= wr_data_i;
        if (eret_i)   exl_q <= 1'b0;
      end
    end
  end

  assign epc_o     = epc_q;
  assign code_o    = code_q;
  assign badaddr_o = badaddr_q;
  assign exl_o     = exl_q;

  assert_epc_capture_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i && !exl_q |=> epc_q == $past(exc_pc_i));
  assert_exl_set_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> exl_q);
  assert_nested_hold_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i && exl_q |=> $stable(epc_q));
  assert_eret_clear_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    eret_i && !exc_valid_i |=> !exl_q);
  assert_badaddr_gate_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_valid_i && exc_addr_valid_i) |=> $stable(badaddr_q));
endmodule

// File: rtl/exc_timer.sv
module exc_timer #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_count_i,
  input  logic            wr_match_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic [XLEN-1:0] count_o,
  output logic [XLEN-1:0] match_o,
  output logic            irq_o
);
  logic [XLEN-1:0] count_q, match_q;
  logic            irq_q;
  logic            hit;

  assign hit = (count_q == match_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      match_q <= '1;
      irq_q   <= 1'b0;
    end else begin
      count_q <= wr_count_i ? wr_data_i : count_q + 1'b1;
      if (wr_match_i) match_q <= wr_data_i;
      // clearing write wins over a simultaneous hit
      irq_q <= wr_match_i ? 1'b0 : (irq_q | hit);
    end
  end

  assign count_o = count_q;
  assign match_o = match_q;
  assign irq_o   = irq_q;

  assert_count_step_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_count_i |=> count_q == $past(count_q) + 1'b1);
  assert_match_clear_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_match_i |=> !irq_q);
  assert_irq_sticky_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !wr_match_i |=> irq_q);
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
  import exc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter bit          VECTORED = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exc_valid_i,
  input  logic [IDX_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]  exc_pc_i,
  input  logic             exc_addr_valid_i,
  input  logic [XLEN-1:0]  exc_addr_i,
  input  logic             eret_i,
  input  logic             reg_wr_i,
  input  logic [IDX_W-1:0] reg_idx_i,
  input  logic [XLEN-1:0]  wr_data_i,
  output logic [XLEN-1:0]  rd_data_o,
  output logic             redirect_o,
  output logic [XLEN-1:0]  redirect_pc_o,
  output logic             exl_o,
  output logic             timer_irq_o
);
  localparam int unsigned CODE_MSB = CODE_LSB + IDX_W - 1;

  logic [XLEN-1:0]  epc, badaddr, count, match, entry;
  logic [IDX_W-1:0] code;
  logic             wr_epc, wr_count, wr_match;

  assign wr_epc   = reg_wr_i && (reg_idx_i == REG_EPC);
  assign wr_count = reg_wr_i && (reg_idx_i == REG_COUNT);
  assign wr_match = reg_wr_i && (reg_idx_i == REG_MATCH);

  exc_capture #(.XLEN(XLEN)) u_capture (
    .clk_i, .rst_ni,
    .exc_valid_i, .exc_code_i, .exc_pc_i, .exc_addr_valid_i, .exc_addr_i,
    .eret_i,
    .wr_epc_i  (wr_epc),
    .wr_data_i,
    .epc_o     (epc),
    .code_o    (code),
    .badaddr_o (badaddr),
    .exl_o
  );

  exc_timer #(.XLEN(XLEN)) u_timer (
    .clk_i, .rst_ni,
    .wr_count_i (wr_count),
    .wr_match_i (wr_match),
    .wr_data_i,
    .count_o    (count),
    .match_o    (match),
    .irq_o      (timer_irq_o)
  );

  exc_vector #(.XLEN(XLEN), .VECTORED(VECTORED)) u_vector (
    .code_i  (exc_code_i),
    .entry_o (entry)
  );

  always_comb begin
    redirect_o    = exc_valid_i | eret_i;
    redirect_pc_o = exc_valid_i ? entry : epc;
  end

  always_comb begin
    rd_data_o = '0;
    unique case (reg_idx_i)
      REG_BADADDR: rd_data_o = badaddr;
      REG_COUNT:   rd_data_o = count;
      REG_MATCH:   rd_data_o = match;
      REG_CAUSE:   rd_data_o[CODE_MSB:CODE_LSB] = code;
      REG_EPC:     rd_data_o = epc;
      default:     rd_data_o = '0;
    endcase
  end

  assert_eret_target_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    eret_i && !exc_valid_i |-> redirect_pc_o == epc);
endmodule

// File: tb/sim_exc_ctrl_regs.sv
`timescale 1ns/1ps
module sim_exc_ctrl_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        exc_valid_i = 0, exc_addr_valid_i = 0, eret_i = 0, reg_wr_i = 0;
  logic [4:0]  exc_code_i = 0, reg_idx_i = 0;
  logic [31:0] exc_pc_i = 0, exc_addr_i = 0, wr_data_i = 0;
  logic [31:0] rd_data_o, redirect_pc_o, rd_v, redirect_pc_v;
  logic        redirect_o, exl_o, timer_irq_o, redirect_v, exl_v, irq_v;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  typedef struct { string req; logic [31:0] exp; } item_t;
  item_t sb_q[$];

  always #2.5 clk_i = ~clk_i;

  exc_ctrl_regs u0 (
    .clk_i, .rst_ni, .exc_valid_i, .exc_code_i, .exc_pc_i, .exc_addr_valid_i,
    .exc_addr_i, .eret_i, .reg_wr_i, .reg_idx_i, .wr_data_i, .rd_data_o,
    .redirect_o, .redirect_pc_o, .exl_o, .timer_irq_o
  );

  exc_ctrl_regs #(.VECTORED(1'b1)) u1 (
    .clk_i, .rst_ni, .exc_valid_i, .exc_code_i, .exc_pc_i, .exc_addr_valid_i,
    .exc_addr_i, .eret_i, .reg_wr_i, .reg_idx_i, .wr_data_i,
    .rd_data_o (rd_v), .redirect_o (redirect_v), .redirect_pc_o (redirect_pc_v),
    .exl_o (exl_v), .timer_irq_o (irq_v)
  );

  // driver side: queue the expected item
  task automatic expect_item(input string r, input logic [31:0] e);
    item_t it;
    it.req = r; it.exp = e;
    sb_q.push_back(it);
  endtask

  // monitor side: pop and compare against what the design shows
  task automatic observe(input logic [31:0] act);
    item_t it;
    it = sb_q.pop_front();
    n_vec++;
    if (act !== it.exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
    end
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] e);
    expect_item(r, e);
    observe(act);
  endtask

  task automatic rd(input logic [4:0] idx, output logic [31:0] v);
    reg_idx_i = idx;
    #0.5 v = rd_data_o;
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic quiet();
    exc_valid_i = 0; exc_addr_valid_i = 0; eret_i = 0; reg_wr_i = 0;
  endtask

  task automatic raise(input logic [4:0] c, input logic [31:0] pc,
                       input logic av, input logic [31:0] a);
    exc_valid_i = 1; exc_code_i = c; exc_pc_i = pc;
    exc_addr_valid_i = av; exc_addr_i = a;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rd(5'd14, v); chk("R1 epc", v, 32'h0);
    rd(5'd13, v); chk("R1 cause", v, 32'h0);
    rd(5'd8,  v); chk("R1 badaddr", v, 32'h0);
    rd(5'd11, v); chk("R1 match", v, 32'hFFFF_FFFF);
    rd(5'd9,  v); chk("R1 count", v, 32'h0);
    chk("R1 flags", {29'b0, exl_o, timer_irq_o, redirect_o}, 32'h0);
    rst_ni = 1;
    cyc();

    // overflow with data address
    raise(5'd12, 32'h0040_0010, 1'b1, 32'h1000_8004);
    #0.5;
    chk("R2 redirect", {31'b0, redirect_o}, 32'h1);
    chk("R2 fixed entry", redirect_pc_o, 32'h8000_0180);
    chk("R3 entry code12", redirect_pc_v, 32'h8000_0180);
    cyc(); quiet();
    chk("R4 exl set", {31'b0, exl_o}, 32'h1);
    rd(5'd14, v); chk("R4 epc", v, 32'h0040_0010);
    rd(5'd13, v); chk("R5 cause ov", v, 32'h0000_0030);
    rd(5'd8,  v); chk("R6 badaddr", v, 32'h1000_8004);

    // nested syscall without data address
    raise(5'd8, 32'h0040_0100, 1'b0, 32'hDEAD_BEEF);
    #0.5 chk("R3 entry code8", redirect_pc_v, 32'h8000_0100);
    cyc(); quiet();
    rd(5'd14, v); chk("R7 epc held", v, 32'h0040_0010);
    rd(5'd13, v); chk("R7 cause updated", v, 32'h0000_0020);
    rd(5'd8,  v); chk("R6 badaddr held", v, 32'h1000_8004);

    // return
    eret_i = 1;
    #0.5;
    chk("R8 eret redirect", {31'b0, redirect_o}, 32'h1);
    chk("R8 eret target", redirect_pc_o, 32'h0040_0010);
    cyc(); quiet();
    chk("R8 exl clear", {31'b0, exl_o}, 32'h0);

    // software register access
    reg_wr_i = 1; reg_idx_i = 5'd14; wr_data_i = 32'h0040_1000;
    cyc(); quiet();
    rd(5'd14, v); chk("R11 epc write", v, 32'h0040_1000);
    reg_wr_i = 1; reg_idx_i = 5'd13; wr_data_i = 32'hFFFF_FFFF;
    cyc(); quiet();
    rd(5'd13, v); chk("R11 cause write ignored", v, 32'h0000_0020);
    reg_wr_i = 1; reg_idx_i = 5'd8; wr_data_i = 32'h1234_5678;
    cyc(); quiet();
    rd(5'd8, v); chk("R11 badaddr write ignored", v, 32'h1000_8004);
    rd(5'd3, v); chk("R11 unmapped", v, 32'h0);

    // reserved instruction together with eret and an EPC write
    raise(5'd10, 32'h0040_0200, 1'b0, 32'h0);
    eret_i = 1; reg_wr_i = 1; reg_idx_i = 5'd14; wr_data_i = 32'h0BAD_0000;
    #0.5;
    chk("R8 priority fixed", redirect_pc_o, 32'h8000_0180);
    chk("R3 entry code10", redirect_pc_v, 32'h8000_0140);
    cyc(); quiet();
    chk("R8 exl kept", {31'b0, exl_o}, 32'h1);
    rd(5'd14, v); chk("R11 exception beats write", v, 32'h0040_0200);
    rd(5'd13, v); chk("R5 cause ri", v, 32'h0000_0028);
    eret_i = 1; cyc(); quiet();

    // interrupt
    raise(5'd0, 32'h0040_0300, 1'b0, 32'h0);
    #0.5 chk("R3 entry code0", redirect_pc_v, 32'h8000_0000);
    cyc(); quiet();
    rd(5'd13, v); chk("R5 cause int", v, 32'h0);
    rd(5'd14, v); chk("R4 epc int", v, 32'h0040_0300);
    eret_i = 1; cyc(); quiet();

    // timer
    reg_wr_i = 1; reg_idx_i = 5'd9; wr_data_i = 32'd1000;
    cyc(); quiet();
    rd(5'd9, v); chk("R9 count load", v, 32'd1000);
    reg_wr_i = 1; reg_idx_i = 5'd11; wr_data_i = 32'd1003;
    cyc(); quiet();
    rd(5'd9, v); chk("R9 count step", v, 32'd1001);
    chk("R10 irq low 1", {31'b0, timer_irq_o}, 32'h0);
    cyc(); chk("R10 irq low 2", {31'b0, timer_irq_o}, 32'h0);
    cyc(); chk("R10 irq low 3", {31'b0, timer_irq_o}, 32'h0);
    cyc(); chk("R10 irq raised", {31'b0, timer_irq_o}, 32'h1);
    rd(5'd9, v); chk("R9 count run", v, 32'd1004);
    cyc(); chk("R10 irq sticky", {31'b0, timer_irq_o}, 32'h1);
    reg_wr_i = 1; reg_idx_i = 5'd11; wr_data_i = 32'hFFFF_FFFF;
    cyc(); quiet();
    chk("R10 irq cleared", {31'b0, timer_irq_o}, 32'h0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule